// File: doc/BRIEF.md
# Serial Register Access Controller

This block is the slave end of a four-wire synchronous serial link. It gives a host access to the control state of a small converter core. The host frames each access with an active-low select. The serial clock idles high. The block drives its output bit after each falling clock edge, and the host samples that bit on the rising edge. The block captures its input bit on the rising edge.

Every access opens with an 8-bit command byte. The command either updates the power-control bits or names one of four registers for a read or a write. The selected register's bits then move through the same wire pair, and after that the interface is ready for the next command.

The block holds four registers:
- an 8-bit status register;
- a 24-bit configuration register;
- an 8-bit filter register;
- a 16-bit result register, which is read-only.

The conversion engine sits outside. It delivers each result as a word with a valid pulse, a clamp flag and a lock level, and it gives a pulse shortly before its next update. An active-low ready output tells the host that an unread result is waiting.

A long run of ones on the data input puts the serial interface back into a known state. The select, clock and data pins are sampled by a system clock that runs at least eight times faster than the serial clock.

Top module: `sra_ctrl`

## Requirements
- R1: After reset, `rdy_n` is 1, `dout_en` is 0, and `cfg_out`, `filt_out`, `stby_out` and `oscpd_out` are all 0. The interface waits for a command byte, and a status read with the lock input low returns 00h.
- R2: The command byte is sent MSB first, with this layout:
  - bit 7 is the write-enable and must be 0;
  - bit 6 selects a read (1) or a write (0);
  - bit 5 is standby;
  - bit 4 is oscillator power-down;
  - bits 3:2 must be 0;
  - bits 1:0 are the register address.

  A command whose bits 3:2 are non-zero has no effect at all. Any other completed command loads bit 5 into `stby_out` and bit 4 into `oscpd_out`.
- R3: While the interface waits for a command, a 1 received where bit 7 is expected is dropped and bit counting does not advance. The seven bits that follow the first 0 complete the command.
- R4: Address 01 selects the 24-bit configuration register. A write to it takes the next 24 bits, MSB first, and updates `cfg_out` once the last bit is in. A read of it returns the same 24 bits.
- R5: Address 10 selects the 8-bit filter register. A write to it changes `filt_out` only if `stby_out` is 1 when the last bit arrives; otherwise the value is discarded. A read of it returns the stored value.
- R6: A pulse on `conv_valid` stores `conv_data` in the result register (address 11, 16 bits, read-only) and drives `rdy_n` low on the next cycle. `rdy_n` returns high when a complete 16-bit read of that register finishes.
- R7: A read at address 00 returns the status byte. From MSB to LSB it is: ready, 0, 0, 0, error, 0, standby, lock. Lock reflects `conv_lock`.
- R8: The error bit is loaded from `conv_clamp` at the same moment that the ready bit is set. It is cleared whenever the ready bit is cleared.
- R9: A pulse on `conv_pre_update` clears the ready bit and the error bit even if the result was never read.
- R10: Thirty-two consecutive rising serial-clock edges with the data input high return the framing logic to command-waiting. The same event clears the configuration, filter, standby and power-down state. A run of 31 ones changes nothing.
- R11: While `csn` is high, `dout_en` is 0 and the framing logic is held at command-waiting. Raising `csn` partway through an access aborts it without touching any register.
- R12: `dout` changes only after a falling serial-clock edge. Registers are sent MSB first, and each complete access returns the interface to command-waiting, so several accesses can follow one another under one select.
- R13: A write command to address 00 or 11 has no data phase. The next bit received begins a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| csn | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| dout_en | output | 1 | Drive enable for `dout`; the pin is released when low |
| rdy_n | output | 1 | Low while an unread result is held |
| conv_data | input | 16 | Result word from the conversion engine |
| conv_valid | input | 1 | One-cycle pulse: new result available |
| conv_clamp | input | 1 | The result being delivered was clamped |
| conv_lock | input | 1 | Clock-lock status of the conversion engine |
| conv_pre_update | input | 1 | One-cycle pulse ahead of the next update |
| cfg_out | output | 24 | Configuration register contents |
| filt_out | output | 8 | Filter register contents |
| stby_out | output | 1 | Standby request |
| oscpd_out | output | 1 | Oscillator power-down request |

## Verification
The assertions check these properties on every cycle:
- The ready output falls after each result pulse.
- The error bit never stands without the ready bit.
- The filter register takes a non-zero value only while in standby.
- The configuration changes only at the end of a write or as a clear.
- `dout` moves only after a falling clock edge.
- A stalled write-enable bit leaves the bit counter at zero.
- The framing logic is held in command-waiting while deselected.

Only the bench's scenarios can show the rest. These include the exact bit order of each register, the status byte layout, and the 31-versus-32 boundary of the resync. They also include the absence of a data phase for some commands, back-to-back accesses under one select, and the fact that an aborted write leaves the registers alone.

// File: rtl/sra_pkg.sv
package sra_pkg;

    localparam int CMD_W       = 8;
    localparam int CFG_W       = 24;
    localparam int FILT_W      = 8;
    localparam int DATA_W      = 16;
    localparam int STAT_W      = 8;
    localparam int SHIFT_W     = CFG_W;
    localparam int CNT_W       = $clog2(SHIFT_W + 1);
    localparam int RESYNC_ONES = 32;
    localparam int ONES_W      = $clog2(RESYNC_ONES + 1);

    typedef enum logic [1:0] {
        ST_CMD = 2'd0,
        ST_WR  = 2'd1,
        ST_RD  = 2'd2
    } xfer_state_e;

    typedef enum logic [1:0] {
        RA_CTRL = 2'b00,
        RA_CFG  = 2'b01,
        RA_FILT = 2'b10,
        RA_DATA = 2'b11
    } reg_addr_e;

    typedef struct packed {
        logic       wen_n;
        logic       rd;
        logic       stby;
        logic       oscpd;
        logic [1:0] rsvd;
        reg_addr_e  addr;
    } cmd_t;

    // Number of bits in the data phase that follows a command.
    function automatic logic [CNT_W-1:0] phase_bits(reg_addr_e a, logic rd);
        case (a)
            RA_CTRL: return rd ? CNT_W'(STAT_W) : '0;
            RA_CFG:  return CNT_W'(CFG_W);
            RA_FILT: return CNT_W'(FILT_W);
            default: return rd ? CNT_W'(DATA_W) : '0;
        endcase
    endfunction

    function automatic logic [STAT_W-1:0] status_byte(logic rdy, logic err,
                                                       logic stby, logic lock);
        return {rdy, 3'b000, err, 1'b0, stby, lock};
    endfunction

endpackage

// File: rtl/sra_sync.sv
module sra_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sra_ready.sv
module sra_ready
    import sra_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_clamp,
    input  logic              pre_clr,
    input  logic              rd_done,
    output logic [DATA_W-1:0] data_q,
    output logic              rdy_q,
    output logic              err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            rdy_q  <= 1'b0;
            err_q  <= 1'b0;
        end else if (load) begin
            data_q <= load_data;
            rdy_q  <= 1'b1;
            err_q  <= load_clamp;
        end else if (rd_done || pre_clr) begin
            rdy_q  <= 1'b0;
            err_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/sra_regs.sv
module sra_regs
    import sra_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               cmd_we,
    input  logic               cmd_stby,
    input  logic               cmd_oscpd,
    input  logic               wr_commit,
    input  reg_addr_e          wr_addr,
    input  logic [SHIFT_W-1:0] wr_data,
    output logic [CFG_W-1:0]   cfg_q,
    output logic [FILT_W-1:0]  filt_q,
    output logic               stby_q,
    output logic               oscpd_q
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cfg_q   <= '0;
            filt_q  <= '0;
            stby_q  <= 1'b0;
            oscpd_q <= 1'b0;
        end else begin
            if (cmd_we) begin
                stby_q  <= cmd_stby;
                oscpd_q <= cmd_oscpd;
            end
            if (wr_commit) begin
                if (wr_addr == RA_CFG)
                    cfg_q <= wr_data[CFG_W-1:0];
                if (wr_addr == RA_FILT && stby_q)
                    filt_q <= wr_data[FILT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/sra_ctrl.sv
module sra_ctrl
    import sra_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    output logic              dout_en,
    output logic              rdy_n,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              conv_valid,
    input  logic              conv_clamp,
    input  logic              conv_lock,
    input  logic              conv_pre_update,
    output logic [CFG_W-1:0]  cfg_out,
    output logic [FILT_W-1:0] filt_out,
    output logic              stby_out,
    output logic              oscpd_out
);
    // Synchronized pins and serial-clock edge detection.
    logic [2:0] sync_q;
    logic       cs_idle, sclk_s, din_s, sclk_d, rise, fall;

    sra_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({csn, sclk, din}),
        .q   (sync_q)
    );

    assign cs_idle = sync_q[2];
    assign sclk_s  = sync_q[1];
    assign din_s   = sync_q[0];

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b1;
        else     sclk_d <= sclk_s;
    end

    assign rise = sclk_s & ~sclk_d;
    assign fall = ~sclk_s & sclk_d;

    // Framing state.
    xfer_state_e        state;
    logic [CNT_W-1:0]   bitcnt;
    logic [CNT_W-1:0]   cur_len;
    reg_addr_e          cur_addr;
    logic [CMD_W-2:0]   cmd_sh;
    logic [SHIFT_W-2:0] sh_in;
    logic [SHIFT_W-1:0] sh_out;
    logic               loaded;
    logic [ONES_W-1:0]  ones_cnt;

    cmd_t               cmd_w;
    logic [SHIFT_W-1:0] wr_word, rd_word;
    logic               active, resync, wen_stall, cmd_done, cmd_ok;
    logic               wr_done, rd_last, rd_data_done;

    // Register file and result holder.
    logic [DATA_W-1:0] data_q;
    logic              rdy_q, err_q;

    assign active    = ~cs_idle;
    assign cmd_w     = cmd_t'({cmd_sh, din_s});
    assign wr_word   = {sh_in, din_s};
    assign resync    = active && rise && din_s &&
                       (ones_cnt == ONES_W'(RESYNC_ONES - 1));
    assign wen_stall = (bitcnt == '0) && din_s;
    assign cmd_done  = active && !resync && rise && (state == ST_CMD) &&
                       !wen_stall && (bitcnt == CNT_W'(CMD_W - 1));
    assign cmd_ok    = !cmd_w.wen_n && (cmd_w.rsvd == 2'b00);
    assign wr_done   = active && !resync && rise && (state == ST_WR) &&
                       (bitcnt == cur_len - 1'b1);
    assign rd_last   = active && !resync && rise && (state == ST_RD) &&
                       (bitcnt == cur_len - 1'b1);
    assign rd_data_done = rd_last && (cur_addr == RA_DATA);

    // Read word, left-aligned so its MSB leaves first.
    always_comb begin
        case (cur_addr)
            RA_CTRL: rd_word = {status_byte(rdy_q, err_q, stby_out, conv_lock),
                                {(SHIFT_W-STAT_W){1'b0}}};
            RA_CFG:  rd_word = cfg_out;
            RA_FILT: rd_word = {filt_out, {(SHIFT_W-FILT_W){1'b0}}};
            default: rd_word = {data_q, {(SHIFT_W-DATA_W){1'b0}}};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_CMD;
            bitcnt   <= '0;
            cur_len  <= '0;
            cur_addr <= RA_CTRL;
            cmd_sh   <= '0;
            sh_in    <= '0;
            sh_out   <= '0;
            loaded   <= 1'b0;
            ones_cnt <= '0;
        end else if (cs_idle) begin
            state    <= ST_CMD;
            bitcnt   <= '0;
            loaded   <= 1'b0;
            ones_cnt <= '0;
        end else begin
            if (rise)
                ones_cnt <= (din_s && !resync) ? ones_cnt + 1'b1 : '0;

            if (resync) begin
                state  <= ST_CMD;
                bitcnt <= '0;
                loaded <= 1'b0;
            end else begin
                case (state)
                    ST_CMD: begin
                        if (rise && !wen_stall) begin
                            cmd_sh <= cmd_w[CMD_W-2:0];
                            if (bitcnt == CNT_W'(CMD_W - 1)) begin
                                bitcnt   <= '0;
                                loaded   <= 1'b0;
                                cur_addr <= cmd_w.addr;
                                cur_len  <= phase_bits(cmd_w.addr, cmd_w.rd);
                                if (cmd_ok && phase_bits(cmd_w.addr, cmd_w.rd) != '0)
                                    state <= cmd_w.rd ? ST_RD : ST_WR;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_WR: begin
                        if (rise) begin
                            sh_in <= wr_word[SHIFT_W-2:0];
                            if (wr_done) begin
                                state  <= ST_CMD;
                                bitcnt <= '0;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RD: begin
                        if (fall) begin
                            loaded <= 1'b1;
                            sh_out <= loaded ? {sh_out[SHIFT_W-2:0], 1'b0} : rd_word;
                        end
                        if (rise) begin
                            if (rd_last) begin
                                state  <= ST_CMD;
                                bitcnt <= '0;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    default: begin
                        state  <= ST_CMD;
                        bitcnt <= '0;
                    end
                endcase
            end
        end
    end

    sra_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .clear     (resync),
        .cmd_we    (cmd_done && cmd_ok),
        .cmd_stby  (cmd_w.stby),
        .cmd_oscpd (cmd_w.oscpd),
        .wr_commit (wr_done),
        .wr_addr   (cur_addr),
        .wr_data   (wr_word),
        .cfg_q     (cfg_out),
        .filt_q    (filt_out),
        .stby_q    (stby_out),
        .oscpd_q   (oscpd_out)
    );

    sra_ready u_ready (
        .clk        (clk),
        .rst        (rst),
        .load       (conv_valid),
        .load_data  (conv_data),
        .load_clamp (conv_clamp),
        .pre_clr    (conv_pre_update),
        .rd_done    (rd_data_done),
        .data_q     (data_q),
        .rdy_q      (rdy_q),
        .err_q      (err_q)
    );

    assign dout    = sh_out[SHIFT_W-1];
    assign dout_en = active;
    assign rdy_n   = ~rdy_q;
endmodule

// File: rtl/sra_ctrl_chk.sv
module sra_ctrl_chk
    import sra_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_idle,
    input logic              rise,
    input logic              fall,
    input logic              din_s,
    input xfer_state_e       state,
    input logic [CNT_W-1:0]  bitcnt,
    input logic              dout,
    input logic              dout_en,
    input logic              conv_valid,
    input logic              rdy_n,
    input logic              err_q,
    input logic [FILT_W-1:0] filt_out,
    input logic              stby_out,
    input logic [CFG_W-1:0]  cfg_out
);
    assert_ready_on_result_R6: assert property (@(posedge clk) disable iff (rst)
        conv_valid |=> !rdy_n);

    assert_err_needs_ready_R8: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !rdy_n);

    assert_filter_only_in_standby_R5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(filt_out) && filt_out != '0) |-> $past(stby_out));

    assert_cfg_only_by_write_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_out) |-> ($past(state) == ST_WR || cfg_out == '0));

    assert_dout_after_fall_R12: assert property (@(posedge clk) disable iff (rst)
        (dout_en && $past(dout_en) && !$stable(dout)) |-> $past(fall));

    assert_deselect_holds_idle_R11: assert property (@(posedge clk) disable iff (rst)
        cs_idle |=> (state == ST_CMD && bitcnt == '0));

    assert_wen_stall_R3: assert property (@(posedge clk) disable iff (rst)
        (!cs_idle && state == ST_CMD && bitcnt == '0 && rise && din_s)
        |=> (state == ST_CMD && bitcnt == '0));
endmodule

bind sra_ctrl sra_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_idle    (cs_idle),
    .rise       (rise),
    .fall       (fall),
    .din_s      (din_s),
    .state      (state),
    .bitcnt     (bitcnt),
    .dout       (dout),
    .dout_en    (dout_en),
    .conv_valid (conv_valid),
    .rdy_n      (rdy_n),
    .err_q      (err_q),
    .filt_out   (filt_out),
    .stby_out   (stby_out),
    .cfg_out    (cfg_out)
);

// File: tb/sra_ctrl_tb.sv
module sra_ctrl_tb;
    import sra_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              csn = 1'b1, sclk = 1'b1, din = 1'b1;
    logic              dout, dout_en, rdy_n;
    logic [DATA_W-1:0] conv_data = '0;
    logic              conv_valid = 1'b0, conv_clamp = 1'b0;
    logic              conv_lock = 1'b0, conv_pre_update = 1'b0;
    logic [CFG_W-1:0]  cfg_out;
    logic [FILT_W-1:0] filt_out;
    logic              stby_out, oscpd_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic [63:0] rx;

    always #2.5 clk = ~clk;

    sra_ctrl u_dut (
        .clk             (clk),
        .rst             (rst),
        .csn             (csn),
        .sclk            (sclk),
        .din             (din),
        .dout            (dout),
        .dout_en         (dout_en),
        .rdy_n           (rdy_n),
        .conv_data       (conv_data),
        .conv_valid      (conv_valid),
        .conv_clamp      (conv_clamp),
        .conv_lock       (conv_lock),
        .conv_pre_update (conv_pre_update),
        .cfg_out         (cfg_out),
        .filt_out        (filt_out),
        .stby_out        (stby_out),
        .oscpd_out       (oscpd_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One select frame: n bits from tx[n-1] downward; rx collects dout.
    task automatic frame(input logic [63:0] tx, input int n, output logic [63:0] r);
        r = '0;
        csn = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b0;
            din  = tx[i];
            repeat (8) @(negedge clk);
            r = {r[62:0], dout};
            sclk = 1'b1;
            repeat (8) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        csn = 1'b1;
        din = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_result(input logic [15:0] d, input logic clamp);
        conv_data  = d;
        conv_clamp = clamp;
        conv_valid = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_status(input string req, input logic [7:0] exp);
        logic [63:0] r;
        frame({48'd0, 8'h40, 8'h00}, 16, r);
        chk(req, {24'd0, r[7:0]}, {24'd0, exp});
    endtask

    task automatic t_reset;
        chk("R1 rdy_n", {31'd0, rdy_n}, 32'd1);
        chk("R1 dout_en", {31'd0, dout_en}, 32'd0);
        chk("R1 cfg", {8'd0, cfg_out}, 32'd0);
        chk("R1 filt", {24'd0, filt_out}, 32'd0);
        chk("R1 stby/oscpd", {30'd0, stby_out, oscpd_out}, 32'd0);
        read_status("R1 status after reset", 8'h00);
    endtask

    task automatic t_config;
        frame({32'd0, 8'h01, 24'hA5C37E}, 32, rx);
        chk("R4 cfg write", {8'd0, cfg_out}, 32'h00A5C37E);
        frame({32'd0, 8'h41, 24'h0}, 32, rx);
        chk("R4 cfg read", {8'd0, rx[23:0]}, 32'h00A5C37E);
    endtask

    task automatic t_filter;
        frame({48'd0, 8'h02, 8'h3C}, 16, rx);
        chk("R5 filter write outside standby", {24'd0, filt_out}, 32'd0);
        frame({56'd0, 8'h24}, 8, rx);
        chk("R2 reserved bits set ignored", {31'd0, stby_out}, 32'd0);
        frame({56'd0, 8'h20}, 8, rx);
        chk("R2 standby from command", {31'd0, stby_out}, 32'd1);
        frame({48'd0, 8'h22, 8'h3C}, 16, rx);
        chk("R5 filter write in standby", {24'd0, filt_out}, 32'h3C);
        frame({48'd0, 8'h72, 8'h00}, 16, rx);
        chk("R5 filter read", {24'd0, rx[7:0]}, 32'h3C);
        chk("R2 stby+oscpd from read command", {30'd0, stby_out, oscpd_out}, 32'd3);
        frame({48'd0, 8'h60, 8'h00}, 16, rx);
        chk("R7 status standby bit", {24'd0, rx[7:0]}, 32'h02);
        frame({56'd0, 8'h00}, 8, rx);
        chk("R2 standby cleared", {30'd0, stby_out, oscpd_out}, 32'd0);
    endtask

    task automatic t_data_ready;
        conv_lock = 1'b1;
        pulse_result(16'hBEEF, 1'b0);
        chk("R6 rdy_n low on result", {31'd0, rdy_n}, 32'd0);
        read_status("R7 status ready+lock", 8'h81);
        frame({40'd0, 8'h43, 16'h0}, 24, rx);
        chk("R6 data read", {16'd0, rx[15:0]}, 32'h0000BEEF);
        chk("R6 rdy_n high after read", {31'd0, rdy_n}, 32'd1);
        read_status("R6 status after read", 8'h01);
    endtask

    task automatic t_err;
        pulse_result(16'hFFFF, 1'b1);
        read_status("R8 error with ready", 8'h89);
        conv_pre_update = 1'b1;
        @(negedge clk);
        conv_pre_update = 1'b0;
        @(negedge clk);
        chk("R9 ready cleared by pre-update", {31'd0, rdy_n}, 32'd1);
        read_status("R8 error cleared with ready", 8'h01);
        pulse_result(16'h1234, 1'b0);
        read_status("R8 no error without clamp", 8'h81);
    endtask

    task automatic t_wen;
        frame({29'd0, 3'b111, 8'h01, 24'h123456}, 35, rx);
        chk("R3 leading ones dropped", {8'd0, cfg_out}, 32'h00123456);
    endtask

    task automatic t_resync;
        frame({32'd0, 8'h01, 24'h5A5A5A}, 32, rx);
        frame({56'd0, 8'h20}, 8, rx);
        frame('1, 31, rx);
        chk("R10 31 ones keep cfg", {8'd0, cfg_out}, 32'h005A5A5A);
        chk("R10 31 ones keep standby", {31'd0, stby_out}, 32'd1);
        frame('1, 40, rx);
        chk("R10 32 ones clear cfg", {8'd0, cfg_out}, 32'd0);
        chk("R10 32 ones clear standby", {31'd0, stby_out}, 32'd0);
        frame({32'hFFFFFFFF, 8'h01, 24'h0000AA}, 64, rx);
        chk("R10 command after resync", {8'd0, cfg_out}, 32'h000000AA);
    endtask

    task automatic t_abort;
        csn = 1'b0;
        repeat (8) @(negedge clk);
        chk("R11 dout_en while selected", {31'd0, dout_en}, 32'd1);
        csn = 1'b1;
        repeat (8) @(negedge clk);
        frame({44'd0, 8'h01, 12'hFFF}, 20, rx);
        chk("R11 dout_en while deselected", {31'd0, dout_en}, 32'd0);
        chk("R11 aborted write", {8'd0, cfg_out}, 32'h000000AA);
        frame({32'd0, 8'h41, 24'h0}, 32, rx);
        chk("R11 fresh command after abort", {8'd0, rx[23:0]}, 32'h000000AA);
    endtask

    task automatic t_b2b;
        frame({8'h01, 24'h00C0DE, 8'h41, 24'h0}, 64, rx);
        chk("R12 back-to-back read", {8'd0, rx[23:0]}, 32'h0000C0DE);
        frame({24'd0, 8'h03, 8'h41, 24'h0}, 40, rx);
        chk("R13 data-register write has no data phase", {8'd0, rx[23:0]}, 32'h0000C0DE);
        frame({24'd0, 8'h00, 8'h41, 24'h0}, 40, rx);
        chk("R13 command-only write", {8'd0, rx[23:0]}, 32'h0000C0DE);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_config();
        t_filter();
        t_data_ready();
        t_err();
        t_wen();
        t_resync();
        t_abort();
        t_b2b();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule